// File: doc/BRIEF.md
# Edge-Serviced Watchdog Timer

This block watches a strobe line that software must keep toggling. Each rising or falling transition on the strobe restarts a timeout counter. If the counter reaches its limit with no transition, the active-low alarm output goes low. The alarm stays low until the strobe moves again, or until the system reset generator reports that reset is active. The counter advances only on clock-enable ticks, so the timeout can be set in slow units (for example 1 ms ticks for a period of about 1.6 s) while the block runs on the fast system clock.

The alarm output can be wired back to the manual reset input of a reset generator. With a stuck strobe, this loop then produces a reset pulse once every timeout plus reset-stretch interval. The counter is held at zero for as long as reset is active, and it starts counting again when reset is released. A supply-valid flag forces the alarm low while the supply is bad and releases it in the same cycle the supply recovers. An enable input stands for a strobe pin left floating: when enable is low the watchdog is idle and quiet.

The controller is a four-state machine. In IDLE (`WD_OFF`) the watchdog is disabled. In COUNTING (`WD_ARMED`) the counter advances on ticks. In HOLD (`WD_HELD`) reset is active and the counter is frozen at zero. In ALARM (`WD_FIRED`) the timeout has expired. The transitions are as follows. From any state, enable low goes to IDLE. From IDLE, enable high goes to HOLD if reset is active, otherwise to COUNTING. From COUNTING, reset active goes to HOLD, and the final tick with no strobe edge goes to ALARM. From HOLD, reset released goes to COUNTING. From ALARM, reset active goes to HOLD, and a strobe edge goes to COUNTING.

Top module: `wdog_edge_timer`

## Requirements
- R1: After `rst_n` is released the machine is in IDLE and `wdo_n` is 1 while `supply_ok` is 1.
- R2: While `wd_enable` is 0, `wdo_n` stays 1 (given `supply_ok` = 1), whatever happens on the strobe, ticks or reset.
- R3: In COUNTING, once TIMEOUT_TICKS tick cycles have passed with no strobe edge, `wdo_n` goes low in the cycle after the final tick. Cycles with `tick` = 0 do not count.
- R4: A rising edge and a falling edge on `wdi` both clear the count. `wdi` passes through two synchronizer flops, so an edge acts on the state at the third rising clock edge after the strobe changes. A strobe pulse one clock wide is detected.
- R5: While `reset_active` is 1 the count is held at zero and `wdo_n` is 1. A full TIMEOUT_TICKS ticks are needed after release before an alarm.
- R6: Once in ALARM, `wdo_n` stays 0 until a strobe edge arrives. The edge returns the machine to COUNTING with a fresh count.
- R7: `reset_active` in ALARM releases `wdo_n`. With `wdo_n` looped back into a reset generator and a static strobe, alarm pulses repeat.
- R8: `supply_ok` = 0 forces `wdo_n` to 0 combinationally. `wdo_n` returns to 1 in the same cycle that `supply_ok` returns to 1, unless the machine is in ALARM.
- R9: A strobe edge that arrives in the same cycle as the final tick wins: no alarm, and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock-enable that advances the timeout counter |
| wdi | input | 1 | Asynchronous strobe serviced by software |
| wd_enable | input | 1 | 1 = watchdog active, 0 = idle (floating-strobe case) |
| reset_active | input | 1 | 1 while the reset generator holds the system in reset |
| supply_ok | input | 1 | 1 while the supply is above threshold |
| wdo_n | output | 1 | Active-low watchdog alarm |

## Verification
The bench goes after the cycle on which the alarm falls. A counter that is off by one, or that counts every clock instead of every tick, fires a cycle or many cycles early. It also makes a strobe edge coincide with the final tick: a design that gives the timeout priority raises a false alarm. Reset is asserted while the alarm is active, and the bench runs a looped-back reset generator. A design that ignores reset in ALARM locks up with the alarm stuck low and never produces repeated pulses. Supply drops are checked a fraction of a cycle after they happen. A registered supply path, or one that waits for a recovery interval, shows a stale alarm level.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_ARMED = 2'd1,
        WD_HELD  = 2'd2,
        WD_FIRED = 2'd3
    } wd_state_e;
endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    // Either polarity of transition counts as service
    assign edge_o = sync_q[SYNC_STAGES-1] ^ last_q;
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int TIMEOUT_TICKS = 1600,
    localparam int CW = $clog2(TIMEOUT_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    output logic          expire,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

    assign expire = run && tick && (count == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          count <= '0;
        else if (!run)       count <= '0;
        else if (tick) begin
            if (count == LAST) count <= '0;
            else               count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_edge_timer.sv
module wdog_edge_timer #(
    parameter int TIMEOUT_TICKS = 1600,
    parameter int SYNC_STAGES   = 2,
    localparam int CW = $clog2(TIMEOUT_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic wdi,
    input  logic wd_enable,
    input  logic reset_active,
    input  logic supply_ok,
    output logic wdo_n
);
    import wdt_pkg::*;

    wd_state_e     state_q, state_d;
    logic          wdi_edge;
    logic          run;
    logic          expire;
    logic [CW-1:0] cnt_q;

    wdt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (wdi),
        .edge_o (wdi_edge)
    );

    // Counting only in ARMED with no service edge and no reset this cycle
    assign run = (state_q == WD_ARMED) && wd_enable && !reset_active && !wdi_edge;

    wdt_tick_counter #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .tick   (tick),
        .expire (expire),
        .count  (cnt_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF: begin
                if (wd_enable) state_d = reset_active ? WD_HELD : WD_ARMED;
            end
            WD_ARMED: begin
                if (!wd_enable)        state_d = WD_OFF;
                else if (reset_active) state_d = WD_HELD;
                else if (expire)       state_d = WD_FIRED;
            end
            WD_HELD: begin
                if (!wd_enable)         state_d = WD_OFF;
                else if (!reset_active) state_d = WD_ARMED;
            end
            WD_FIRED: begin
                if (!wd_enable)        state_d = WD_OFF;
                else if (reset_active) state_d = WD_HELD;
                else if (wdi_edge)     state_d = WD_ARMED;
            end
            default: state_d = WD_OFF;
        endcase
    end

    // Output: alarm state or bad supply; supply recovery releases at once
    always_comb begin
        wdo_n = supply_ok && (state_q != WD_FIRED);
    end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int TIMEOUT_TICKS = 1600,
    localparam int CW = $clog2(TIMEOUT_TICKS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             wd_enable,
    input logic             reset_active,
    input logic             supply_ok,
    input logic             wdo_n,
    input logic             wdi_edge,
    input wdt_pkg::wd_state_e state,
    input logic [CW-1:0]    cnt
);
    import wdt_pkg::*;

    a_r8_supply_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> !wdo_n);

    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wd_enable) && supply_ok |-> wdo_n);

    a_r5_reset_releases: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reset_active) && supply_ok |-> wdo_n);

    a_r3_fire_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdo_n) && supply_ok && $past(supply_ok) |-> $past(tick));

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(TIMEOUT_TICKS));

    a_r6_alarm_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        state == WD_FIRED && wd_enable && !reset_active && !wdi_edge |=> state == WD_FIRED);

    a_r4_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wdi_edge |=> cnt == '0);
endmodule

bind wdog_edge_timer wdt_checker #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .wd_enable    (wd_enable),
    .reset_active (reset_active),
    .supply_ok    (supply_ok),
    .wdo_n        (wdo_n),
    .wdi_edge     (wdi_edge),
    .state        (state_q),
    .cnt          (cnt_q)
);

// File: tb/wdog_edge_timer_tb.sv
module wdog_edge_timer_tb;
    localparam int T = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic wdi = 1'b0;
    logic wd_enable = 1'b0;
    logic reset_active = 1'b0;
    logic supply_ok = 1'b1;
    logic wdo_n;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R1";
    int cyc = 0;
    int tick_div = 1;
    bit tick_en = 1;

    // behavioural reference state
    int mode = 0;            // 0 idle, 1 counting, 2 alarm, 3 hold
    int count = 0;
    int hist[3] = '{0, 0, 0};

    always #2 clk = ~clk;    // 250 MHz

    wdog_edge_timer #(.TIMEOUT_TICKS(T)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wdi(wdi),
        .wd_enable(wd_enable), .reset_active(reset_active),
        .supply_ok(supply_ok), .wdo_n(wdo_n)
    );

    always @(negedge clk) begin
        cyc++;
        tick = tick_en && ((cyc % tick_div) == 0);
    end

    task automatic chk(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s wdo_n actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit edge_seen;
        if (!rst_n) begin
            mode = 0; count = 0; hist = '{0, 0, 0};
        end else begin
            edge_seen = (hist[1] != hist[2]);
            case (mode)
                0: begin count = 0; if (wd_enable) mode = reset_active ? 3 : 1; end
                1: begin
                    if (!wd_enable) begin mode = 0; count = 0; end
                    else if (reset_active) begin mode = 3; count = 0; end
                    else if (edge_seen) count = 0;
                    else if (tick) begin
                        count++;
                        if (count == T) begin mode = 2; count = 0; end
                    end
                end
                2: begin
                    count = 0;
                    if (!wd_enable) mode = 0;
                    else if (reset_active) mode = 3;
                    else if (edge_seen) mode = 1;
                end
                default: begin
                    count = 0;
                    if (!wd_enable) mode = 0;
                    else if (!reset_active) mode = 1;
                end
            endcase
            hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = int'(wdi);
        end
        #1;
        chk(cur_req, wdo_n, supply_ok && (mode != 2));
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int falls;
        logic prev;
        int stretch;
        step(3);
        rst_n = 1'b1;
        step(2);
        cur_req = "R1"; chk("R1", wdo_n, 1'b1);

        cur_req = "R2";
        for (int i = 0; i < 40; i++) begin
            reset_active = (i % 7) == 0; wdi = (i % 5) == 0; step(1);
        end
        reset_active = 0; wdi = 0;
        chk("R2", wdo_n, 1'b1);

        cur_req = "R3"; tick_en = 0; wd_enable = 1; step(60);
        chk("R3", wdo_n, 1'b1);
        tick_en = 1; step(T + 4);
        chk("R3", wdo_n, 1'b0);

        cur_req = "R6"; step(20); chk("R6", wdo_n, 1'b0);
        wdi = 1; step(5); chk("R6", wdo_n, 1'b1);

        cur_req = "R4";
        for (int i = 0; i < 10; i++) begin step(T - 4); wdi = ~wdi; end
        chk("R4", wdo_n, 1'b1);
        step(T - 4); wdi = ~wdi; step(1); wdi = ~wdi;   // one-clock pulse
        step(T - 3); chk("R4", wdo_n, 1'b1);
        step(T); chk("R4", wdo_n, 1'b0);

        cur_req = "R7"; reset_active = 1; step(2); chk("R7", wdo_n, 1'b1);
        cur_req = "R5"; step(40); chk("R5", wdo_n, 1'b1);
        reset_active = 0; step(T - 2); chk("R5", wdo_n, 1'b1);
        step(6); chk("R5", wdo_n, 1'b0);

        cur_req = "R7"; falls = 0; stretch = 0; prev = wdo_n;
        for (int i = 0; i < 150; i++) begin
            if (!wdo_n) stretch = 6; else if (stretch > 0) stretch--;
            reset_active = (stretch > 0);
            if (prev && !wdo_n) falls++;
            prev = wdo_n;
            step(1);
        end
        reset_active = 0;
        total++;
        if (falls < 3) begin
            bad++;
            $display("FAIL R7 alarm pulses actual=%0d expected>=3", falls);
        end
        wdi = ~wdi; step(6);

        cur_req = "R8"; supply_ok = 0; #1; chk("R8", wdo_n, 1'b0);
        step(3); supply_ok = 1; #1; chk("R8", wdo_n, 1'b1);

        cur_req = "R9"; tick_div = 3;
        for (int gap = 30; gap < 44; gap++) begin step(gap); wdi = ~wdi; end
        step(3 * T + 10); chk("R9", wdo_n, 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog run hung actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule